// File: doc/BRIEF.md
# Level-Sensitive Interrupt Cause/Mask Controller

This block collects up to 32 level-sensitive interrupt requests and sends one combined request to a parent interrupt controller. Each request line has one bit in a cause register. The bit is captured on every clock edge where the line is high. Software acknowledges a captured bit by writing a one to it. A mask register of the same width decides which captured bits count.

A bit that is both captured and enabled is pending. The OR of all pending bits is registered and drives the combined output. A lowest-index-first encoder also reports which pending source should be serviced next, together with a valid flag.

Software reaches the two registers through a plain word-wide register port. Writes take effect on the clock edge. Reads are combinational from the address, so the port has no back-pressure: every write is accepted in the cycle it is presented. A handler should mask a source before acknowledging it, because a line that is still high captures its bit again at once.

Top module: `irq_cause_mask_ctrl`

## Requirements
- R1: While reset is low, and on the first cycle after it, the cause register and the mask register read 0, `irq_o` is 0 and `sel_valid_o` is 0.
- R2: A source line high at a clock edge sets its cause bit at that edge, whatever its mask bit holds. The bit can be read at byte offset 0x00 (source n at bit n) from the following cycle.
- R3: A write to offset 0x00 clears every cause bit written as 1 and leaves the bits written as 0 unchanged. If the source is high in the same cycle, the request wins and the bit stays set.
- R4: A write to offset 0x04 replaces the whole mask register, and the mask can be read back at offset 0x04. A mask bit of 1 enables the source and 0 disables it.
- R5: `irq_o` equals the OR of (cause AND mask) as it was one clock earlier.
- R6: `sel_valid_o` is 1 exactly when (cause AND mask) is non-zero. While it is 1, `sel_idx_o` holds the lowest set bit of that AND. While it is 0, `sel_idx_o` is 0.
- R7: Writes to any other offset change nothing, and reads of any other offset return 0.
- R8: Writing 0 to the mask and then all ones to the cause register, with all sources low, leaves both registers at 0, `sel_valid_o` at 0 and `irq_o` at 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level-sensitive request lines, one per source |
| reg_wr_en | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_o | output | 1 | Registered combined request to the parent controller |
| sel_idx_o | output | 5 | Index of the lowest pending source |
| sel_valid_o | output | 1 | High when at least one source is pending |

## Verification
Each result has a fixed delay. Register contents, `sel_idx_o` and `sel_valid_o` reflect a source level or a write one clock edge after it is presented. `irq_o` follows one edge later than that, so it reports the pending set that existed before the most recent edge. The bench drives each stimulus at a falling edge and updates its reference model at the next rising edge, recording the old pending OR as the expected `irq_o`. It then queues expectations that the monitor compares half a cycle after that rising edge, which always keeps them one register stage behind the stimulus.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  // Register targeted by a bus access
  typedef enum logic [1:0] {
    REG_CAUSE = 2'd0,
    REG_MASK  = 2'd1,
    REG_NONE  = 2'd2
  } reg_sel_e;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CAUSE_OFS = 0,
  parameter int MASK_OFS  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output reg_sel_e          sel,
  output logic              cause_wr,
  output logic              mask_wr
);

  localparam logic [ADDR_W-1:0] CauseAddr = ADDR_W'(CAUSE_OFS);
  localparam logic [ADDR_W-1:0] MaskAddr  = ADDR_W'(MASK_OFS);

  always_comb begin
    if (addr == CauseAddr)     sel = REG_CAUSE;
    else if (addr == MaskAddr) sel = REG_MASK;
    else                       sel = REG_NONE;
  end

  assign cause_wr = wr_en && (sel == REG_CAUSE);
  assign mask_wr  = wr_en && (sel == REG_MASK);

endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src,
  input  logic               clr_wr,
  input  logic [NUM_SRC-1:0] clr_bits,
  output logic [NUM_SRC-1:0] cause
);

  // One capture flop per source: a set from the line beats a clear from software
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    logic clr_this;
    assign clr_this = clr_wr && clr_bits[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cause[g] <= 1'b0;
      else if (src[g])   cause[g] <= 1'b1;
      else if (clr_this) cause[g] <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] mask
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mask <= '0;
    else if (wr) mask <= wdata;
  end

endmodule

// File: rtl/irq_lowest_enc.sv
module irq_lowest_enc #(
  parameter int NUM_SRC = 32,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] req,
  output logic [IDX_W-1:0]   idx,
  output logic               valid
);

  // Scan from the top so the lowest set bit is the last one written
  always_comb begin
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign valid = |req;

endmodule

// File: rtl/irq_cause_mask_ctrl.sv
module irq_cause_mask_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int ADDR_W    = 4,
  parameter int CAUSE_OFS = 0,
  parameter int MASK_OFS  = 4,
  localparam int IDX_W    = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               reg_wr_en,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [NUM_SRC-1:0] reg_wdata,
  output logic [NUM_SRC-1:0] reg_rdata,
  output logic               irq_o,
  output logic [IDX_W-1:0]   sel_idx_o,
  output logic               sel_valid_o
);

  reg_sel_e           acc_sel;
  logic               cause_wr;
  logic               mask_wr;
  logic [NUM_SRC-1:0] cause_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] pending;

  irq_reg_decode #(
    .ADDR_W(ADDR_W), .CAUSE_OFS(CAUSE_OFS), .MASK_OFS(MASK_OFS)
  ) u_dec (
    .addr(reg_addr), .wr_en(reg_wr_en), .sel(acc_sel),
    .cause_wr(cause_wr), .mask_wr(mask_wr)
  );

  irq_cause_bank #(.NUM_SRC(NUM_SRC)) u_cause (
    .clk(clk), .rst_n(rst_n), .src(src_i),
    .clr_wr(cause_wr), .clr_bits(reg_wdata), .cause(cause_q)
  );

  irq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr(mask_wr),
    .wdata(reg_wdata), .mask(mask_q)
  );

  assign pending = cause_q & mask_q;

  irq_lowest_enc #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_enc (
    .req(pending), .idx(sel_idx_o), .valid(sel_valid_o)
  );

  // Combined request, one register stage toward the parent
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |pending;
  end

  always_comb begin
    unique case (acc_sel)
      REG_CAUSE: reg_rdata = cause_q;
      REG_MASK:  reg_rdata = mask_q;
      default:   reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int NUM_SRC   = 32,
  parameter int ADDR_W    = 4,
  parameter int CAUSE_OFS = 0,
  parameter int MASK_OFS  = 4,
  parameter int IDX_W     = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_i,
  input logic               reg_wr_en,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [NUM_SRC-1:0] reg_wdata,
  input logic               irq_o,
  input logic [IDX_W-1:0]   sel_idx_o,
  input logic               sel_valid_o,
  input logic [NUM_SRC-1:0] cause_q,
  input logic [NUM_SRC-1:0] mask_q
);

  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] below;
  logic               wr_cause;
  logic               wr_mask;

  assign pend     = cause_q & mask_q;
  assign below    = ({{(NUM_SRC-1){1'b0}}, 1'b1} << sel_idx_o) - 1'b1;
  assign wr_cause = reg_wr_en && (reg_addr == ADDR_W'(CAUSE_OFS));
  assign wr_mask  = reg_wr_en && (reg_addr == ADDR_W'(MASK_OFS));

  // R2
  src_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i != '0) |=> ((cause_q & $past(src_i)) == $past(src_i)));

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cause |=> ((cause_q & $past(reg_wdata & ~src_i)) == '0));

  // R4
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == $past(reg_wdata)));

  // R5
  irq_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|pend)));

  // R6
  valid_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid_o == (pend != '0));

  // R6
  lowest_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid_o |-> (pend[sel_idx_o] && ((pend & below) == '0)));

  // R6
  idle_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid_o |-> (sel_idx_o == '0));

endmodule

bind irq_cause_mask_ctrl irq_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .CAUSE_OFS(CAUSE_OFS),
  .MASK_OFS(MASK_OFS), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_wr_en(reg_wr_en),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq_o(irq_o),
  .sel_idx_o(sel_idx_o), .sel_valid_o(sel_valid_o),
  .cause_q(cause_q), .mask_q(mask_q)
);

// File: tb/irq_cause_mask_ctrl_tb.sv
`timescale 1ns/1ps
module irq_cause_mask_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic        reg_wr_en = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;
  logic [4:0]  sel_idx_o;
  logic        sel_valid_o;

  always #2.5 clk = ~clk;

  irq_cause_mask_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .sel_idx_o(sel_idx_o), .sel_valid_o(sel_valid_o)
  );

  typedef struct {
    int          req;
    int          kind;   // 0 rdata, 1 irq, 2 valid, 3 index
    logic [31:0] exp;
  } item_t;

  item_t q[$];
  event  sample_ev;
  int    n_vec = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  // Reference model built from the requirements
  logic [31:0] m_cause = '0;
  logic [31:0] m_mask = '0;
  logic        m_irq = 1'b0;

  // Monitor: pops and compares
  initial begin
    forever begin
      @(sample_ev);
      while (q.size() != 0) begin
        item_t it;
        logic [31:0] got;
        it = q.pop_front();
        case (it.kind)
          0:       got = reg_rdata;
          1:       got = {31'd0, irq_o};
          2:       got = {31'd0, sel_valid_o};
          default: got = {27'd0, sel_idx_o};
        endcase
        n_vec++;
        if (got !== it.exp) begin
          n_fail++;
          $display("FAIL R%0d kind %0d actual %h expected %h", it.req, it.kind, got, it.exp);
        end
      end
    end
  end

  task automatic flush();
    #0.1;
    ->sample_ev;
    wait (q.size() == 0);
  endtask

  task automatic push(input int req, input int kind, input logic [31:0] exp);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic expect_all(input int req);
    logic [31:0] pend;
    logic [4:0]  lo;
    pend = m_cause & m_mask;
    lo = '0;
    for (int i = 31; i >= 0; i--) if (pend[i]) lo = 5'(i);
    reg_addr = 4'h0; #0.2; push(req, 0, m_cause); flush();
    reg_addr = 4'h4; #0.2; push(req, 0, m_mask);  flush();
    push(req, 1, {31'd0, m_irq});
    push(req, 2, {31'd0, (pend != 0)});
    push(req, 3, {27'd0, lo});
    flush();
  endtask

  // Driver: one clock of stimulus, then model update
  task automatic tick(input logic [31:0] src, input bit wr,
                      input logic [3:0] a, input logic [31:0] d);
    src_i = src; reg_wr_en = wr; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    m_irq = |(m_cause & m_mask);
    if (wr && a == 4'h0) m_cause = m_cause & ~d;
    m_cause = m_cause | src;
    if (wr && a == 4'h4) m_mask = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    expect_all(1);
    rst_n = 1'b1;
    tick('0, 0, 4'h0, '0);
    expect_all(1);

    // R2: capture with mask off
    tick(32'h8, 0, 4'h0, '0);
    expect_all(2);
    tick('0, 0, 4'h0, '0);
    expect_all(2);

    // R4: mask write and readback
    tick('0, 1, 4'h4, 32'h0000_0418);
    expect_all(4);
    // R5: irq one cycle after pending
    tick('0, 0, 4'h0, '0);
    expect_all(5);

    // R6: two pending, lowest wins
    tick(32'h10, 0, 4'h0, '0);
    expect_all(6);

    // R3: clear bit 3 only
    tick('0, 1, 4'h0, 32'h8);
    expect_all(3);

    // R3: clear collides with held request on bit 10
    tick(32'h400, 1, 4'h0, 32'h410);
    expect_all(3);
    tick('0, 1, 4'h0, 32'h400);
    expect_all(3);
    tick('0, 0, 4'h0, '0);
    expect_all(5);

    // R7: other offsets ignored
    tick(32'h1, 0, 4'h0, '0);
    tick('0, 1, 4'h8, 32'hFFFF_FFFF);
    tick('0, 1, 4'hC, 32'hFFFF_FFFF);
    expect_all(7);
    reg_addr = 4'h8; #0.2; push(7, 0, 32'h0); flush();

    // R6: high sources with everything enabled
    tick(32'hF000_0000, 1, 4'h4, 32'hFFFF_FFFF);
    tick('0, 1, 4'h0, 32'h1);
    expect_all(6);
    tick('0, 1, 4'h0, 32'h7000_0000);
    expect_all(6);

    // R8: quiesce
    tick('0, 1, 4'h4, 32'h0);
    tick('0, 1, 4'h0, 32'hFFFF_FFFF);
    expect_all(8);
    tick('0, 0, 4'h0, '0);
    expect_all(8);

    // R1: source held through reset
    src_i = 32'h1;
    rst_n = 1'b0;
    m_cause = '0; m_mask = '0; m_irq = 1'b0;
    repeat (2) @(negedge clk);
    expect_all(1);
    rst_n = 1'b1;
    tick(32'h1, 0, 4'h0, '0);
    expect_all(2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule